// File: doc/BRIEF.md
# PS/2 Keyboard Receiver and Key-Event Decoder

This block listens to a keyboard on the two open-collector lines of a PS/2 port, using a fast system clock to oversample them. The slow device clock passes through a two-flop synchronizer and a run-length filter. Each accepted falling edge shifts one bit into an eleven-bit frame. A finished frame is checked for its start bit, stop bit and odd parity. A good frame is put out as a raw byte. A bad one raises an error strobe and is dropped.

A small decoder follows the byte stream and tracks the two prefix bytes, the extension marker (0xE0) and the release marker (0xF0). Any other byte closes a sequence. It produces exactly one key event, made of a scan code, a release flag and an extended flag. The host can keep the keyboard from sending by raising `inhibit_i`. The block then pulls the clock line low through `ps2_clk_oe` and drops any partly received frame.

Top module: `ps2_key_rx`

## Requirements
- R1: A frame is a 0 start bit, eight data bits with the least significant bit first, an odd parity bit and a 1 stop bit, each taken at a falling edge of the device clock. A good frame puts its data on `byte_data` together with a one-cycle `byte_valid` pulse. This includes prefix bytes.
- R2: A frame whose start bit is 1, whose stop bit is 0, or whose nine data-plus-parity bits hold an even number of ones gives a one-cycle `frame_err` pulse. It gives no `byte_valid` and no key event.
- R3: A byte other than 0xE0 or 0xF0 that arrives with no prefix pending gives a one-cycle `key_valid` pulse in the cycle after its `byte_valid`. The pulse carries `key_code` set to the byte, with `key_release` = 0 and `key_ext` = 0.
- R4: 0xF0 followed by a code gives one event with `key_release` = 1 and `key_ext` = 0.
- R5: 0xE0 followed by a code gives one event with `key_ext` = 1. The sequence 0xE0 0xF0 code gives one event with both flags set. Prefix bytes on their own give no event.
- R6: A code that repeats because the key is held gives a further make event each time it arrives.
- R7: A frame error clears any pending prefix, so the next code is reported as a plain make.
- R8: A pulse on the clock line shorter than `FILT_LEN` system-clock samples is not taken as an edge.
- R9: When a frame has started and no falling edge arrives for `IDLE_LIMIT` system cycles, the partial frame is dropped without an error. The next frame then decodes correctly.
- R10: `ps2_clk_oe` is 1 in the cycle after `inhibit_i` is sampled high and 0 after it is sampled low. While `inhibit_i` is high, edges are ignored and any partial frame is dropped.
- R11: After reset, all strobes and `ps2_clk_oe` are 0 and no prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ps2_clk_i | input | 1 | Device clock line as seen at the pad |
| ps2_dat_i | input | 1 | Device data line as seen at the pad |
| inhibit_i | input | 1 | Request to hold the device off |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| byte_valid | output | 1 | One-cycle strobe for a good received byte |
| byte_data | output | 8 | Received byte |
| frame_err | output | 1 | One-cycle strobe for a start, stop or parity failure |
| key_valid | output | 1 | One-cycle key event strobe |
| key_code | output | 8 | Scan code of the event |
| key_release | output | 1 | 1 when the event is a key release |
| key_ext | output | 1 | 1 when the event is an extended key |

## Verification
Two things can fall in the same cycle: a host inhibit and the acceptance of a filtered falling edge. The bench provokes this by raising `inhibit_i` partway into a frame, at a sweep of offsets after a device clock fall. The sweep covers points before, at and after the cycle in which the filter passes that edge. For every offset, the aborted frame must leave no byte, no error and no event behind. The next full frame must decode to exactly the byte that was sent.

// File: rtl/ps2_kb_pkg.sv
package ps2_kb_pkg;

    localparam logic [7:0] PFX_EXT  = 8'hE0;
    localparam logic [7:0] PFX_REL  = 8'hF0;
    localparam int         FRAME_W  = 11;
    localparam int         SHIFT_W  = FRAME_W - 1;
    localparam int         BITCNT_W = $clog2(FRAME_W);

    // One serial frame, start bit in the least significant position
    typedef struct packed {
        logic       stop;
        logic       par;
        logic [7:0] data;
        logic       start;
    } ps2_frame_t;

    // Decoded key event
    typedef struct packed {
        logic       ext;
        logic       rel;
        logic [7:0] code;
    } key_evt_t;

    // Pending prefix state carried between bytes
    typedef struct packed {
        logic ext;
        logic rel;
    } pfx_state_t;

    function automatic logic frame_good(ps2_frame_t f);
        return (f.start == 1'b0) && (f.stop == 1'b1) && (^{f.par, f.data} == 1'b1);
    endfunction

    function automatic logic is_prefix(logic [7:0] b);
        return (b == PFX_EXT) || (b == PFX_REL);
    endfunction

endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_raw,
    input  logic dat_raw,
    output logic fall_stb,
    output logic dat_s
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] RUN_END = CW'(FILT_LEN - 1);

    logic [1:0]    clk_sync;
    logic [1:0]    dat_sync;
    logic          clk_stable;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sync <= 2'b11;
            dat_sync <= 2'b11;
        end else begin
            clk_sync <= {clk_sync[0], clk_raw};
            dat_sync <= {dat_sync[0], dat_raw};
        end
    end

    // A new level is taken only after FILT_LEN consecutive differing samples
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_stable <= 1'b1;
            run_cnt    <= '0;
            fall_stb   <= 1'b0;
        end else begin
            fall_stb <= 1'b0;
            if (clk_sync[1] != clk_stable) begin
                if (run_cnt == RUN_END) begin
                    clk_stable <= clk_sync[1];
                    run_cnt    <= '0;
                    fall_stb   <= ~clk_sync[1];
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

    assign dat_s = dat_sync[1];

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
    import ps2_kb_pkg::*;
#(
    parameter int IDLE_LIMIT = 200000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fall_stb,
    input  logic       dat_s,
    input  logic       abort_i,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       frame_err
);
    localparam int IW = $clog2(IDLE_LIMIT + 1);
    localparam logic [IW-1:0]       IDLE_END = IW'(IDLE_LIMIT - 1);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(FRAME_W - 1);

    logic [BITCNT_W-1:0] bit_cnt;
    logic [SHIFT_W-1:0]  shreg;
    logic [IW-1:0]       idle_cnt;
    logic                idle_hit;
    ps2_frame_t          full;

    assign idle_hit = (bit_cnt != '0) && (idle_cnt == IDLE_END);
    assign full     = ps2_frame_t'({dat_s, shreg});

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            idle_cnt   <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            frame_err  <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            frame_err  <= 1'b0;
            if (abort_i) begin
                bit_cnt  <= '0;
                idle_cnt <= '0;
            end else if (fall_stb) begin
                idle_cnt <= '0;
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt <= '0;
                    if (frame_good(full)) begin
                        byte_valid <= 1'b1;
                        byte_data  <= full.data;
                    end else begin
                        frame_err <= 1'b1;
                    end
                end else begin
                    shreg   <= {dat_s, shreg[SHIFT_W-1:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (idle_hit) begin
                bit_cnt  <= '0;
                idle_cnt <= '0;
            end else if (bit_cnt != '0) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ps2_prefix_dec.sv
module ps2_prefix_dec
    import ps2_kb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       frame_err,
    output logic       key_valid,
    output key_evt_t   key_evt
);
    pfx_state_t pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= '0;
            key_valid <= 1'b0;
            key_evt   <= '0;
        end else begin
            key_valid <= 1'b0;
            if (frame_err) begin
                pend <= '0;
            end else if (byte_valid) begin
                if (byte_data == PFX_EXT) begin
                    pend.ext <= 1'b1;
                end else if (byte_data == PFX_REL) begin
                    pend.rel <= 1'b1;
                end else begin
                    key_valid    <= 1'b1;
                    key_evt.code <= byte_data;
                    key_evt.ext  <= pend.ext;
                    key_evt.rel  <= pend.rel;
                    pend         <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/ps2_key_rx.sv
module ps2_key_rx
    import ps2_kb_pkg::*;
#(
    parameter int FILT_LEN   = 8,
    parameter int IDLE_LIMIT = 200000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    input  logic       inhibit_i,
    output logic       ps2_clk_oe,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       frame_err,
    output logic       key_valid,
    output logic [7:0] key_code,
    output logic       key_release,
    output logic       key_ext
);
    logic     fall_stb;
    logic     dat_s;
    key_evt_t evt;

    always_ff @(posedge clk) begin
        if (rst) ps2_clk_oe <= 1'b0;
        else     ps2_clk_oe <= inhibit_i;
    end

    ps2_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .clk_raw  (ps2_clk_i),
        .dat_raw  (ps2_dat_i),
        .fall_stb (fall_stb),
        .dat_s    (dat_s)
    );

    ps2_frame_rx #(.IDLE_LIMIT(IDLE_LIMIT)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .fall_stb   (fall_stb),
        .dat_s      (dat_s),
        .abort_i    (inhibit_i),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .frame_err  (frame_err)
    );

    ps2_prefix_dec u_dec (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .frame_err  (frame_err),
        .key_valid  (key_valid),
        .key_evt    (evt)
    );

    assign key_code    = evt.code;
    assign key_release = evt.rel;
    assign key_ext     = evt.ext;

endmodule

// File: rtl/ps2_key_rx_chk.sv
module ps2_key_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       inhibit_i,
    input logic       ps2_clk_oe,
    input logic       byte_valid,
    input logic       frame_err,
    input logic       key_valid,
    input logic [7:0] key_code
);
    // R2: a frame is either good or bad, never both
    assert_byte_err_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid && frame_err));

    // R3: an event follows its byte by one cycle
    assert_evt_after_byte_R3: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> $past(byte_valid));

    // R3: event strobe lasts one cycle
    assert_evt_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> !key_valid);

    // R5: prefix bytes never appear as an event code
    assert_no_prefix_evt_R5: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> (key_code != 8'hE0 && key_code != 8'hF0));

    // R10: clock line is pulled low the cycle after inhibit
    assert_inhibit_drive_R10: assert property (@(posedge clk) disable iff (rst)
        inhibit_i |=> ps2_clk_oe);

    // R10: no byte completes while inhibited
    assert_inhibit_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (inhibit_i && $past(inhibit_i)) |-> !byte_valid && !frame_err);

endmodule

bind ps2_key_rx ps2_key_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .inhibit_i  (inhibit_i),
    .ps2_clk_oe (ps2_clk_oe),
    .byte_valid (byte_valid),
    .frame_err  (frame_err),
    .key_valid  (key_valid),
    .key_code   (key_code)
);

// File: tb/ps2_key_rx_test.sv
module ps2_key_rx_test;

    localparam int FILT = 4;
    localparam int IDLE = 500;
    localparam int HALF = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dev_clk = 1'b1;
    logic dev_dat = 1'b1;
    logic glitch = 1'b0;
    logic inhibit_i = 1'b0;
    logic line_clk;
    logic ps2_clk_oe, byte_valid, frame_err, key_valid, key_release, key_ext;
    logic [7:0] byte_data, key_code;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    string cur_req = "R11";

    // Reference model state
    logic [7:0] exp_bytes[$];
    logic [9:0] exp_evts[$];
    int  exp_errs = 0;
    bit  m_ext = 0;
    bit  m_rel = 0;

    always #5 clk = ~clk;

    assign line_clk = dev_clk & ~ps2_clk_oe & ~glitch;

    ps2_key_rx #(.FILT_LEN(FILT), .IDLE_LIMIT(IDLE)) uut (
        .clk(clk), .rst(rst), .ps2_clk_i(line_clk), .ps2_dat_i(dev_dat),
        .inhibit_i(inhibit_i), .ps2_clk_oe(ps2_clk_oe),
        .byte_valid(byte_valid), .byte_data(byte_data), .frame_err(frame_err),
        .key_valid(key_valid), .key_code(key_code),
        .key_release(key_release), .key_ext(key_ext)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare outputs with the model on every clock
    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                if (exp_bytes.size() == 0) check(0, cur_req, "unexpected byte", byte_data, 0);
                else begin
                    logic [7:0] eb;
                    eb = exp_bytes.pop_front();
                    check(byte_data == eb, cur_req, "byte", byte_data, eb);
                end
            end
            if (key_valid) begin
                if (exp_evts.size() == 0)
                    check(0, cur_req, "unexpected event", {key_ext, key_release, key_code}, 0);
                else begin
                    logic [9:0] ee;
                    ee = exp_evts.pop_front();
                    check({key_ext, key_release, key_code} == ee, cur_req, "event",
                          {key_ext, key_release, key_code}, ee);
                end
            end
            if (frame_err) begin
                check(exp_errs > 0, cur_req, "unexpected frame error", 1, 0);
                if (exp_errs > 0) exp_errs--;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            fails++;
            tests++;
            $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_byte(input logic [7:0] b);
        exp_bytes.push_back(b);
        if (b == 8'hE0) m_ext = 1;
        else if (b == 8'hF0) m_rel = 1;
        else begin
            exp_evts.push_back({m_ext, m_rel, b});
            m_ext = 0;
            m_rel = 0;
        end
    endtask

    task automatic clock_bit(input logic v);
        dev_dat = v;
        wait_cyc(HALF);
        dev_clk = 1'b0;
        wait_cyc(HALF);
        dev_clk = 1'b1;
    endtask

    // kind: 0 good, 1 bad parity, 2 bad stop, 3 bad start
    task automatic send(input logic [7:0] b, input int kind);
        logic [10:0] f;
        f = {1'b1, ~^b, b, 1'b0};
        if (kind == 1) f[9] = ~f[9];
        if (kind == 2) f[10] = 1'b0;
        if (kind == 3) f[0] = 1'b1;
        if (kind == 0) model_byte(b);
        else begin
            exp_errs++;
            m_ext = 0;
            m_rel = 0;
        end
        for (int i = 0; i < 11; i++) clock_bit(f[i]);
        dev_dat = 1'b1;
        wait_cyc(3 * HALF);
    endtask

    task automatic send_partial(input logic [7:0] b, input int nbits);
        logic [10:0] f;
        f = {1'b1, ~^b, b, 1'b0};
        for (int i = 0; i < nbits; i++) clock_bit(f[i]);
        dev_dat = 1'b1;
    endtask

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R11";
        check(!byte_valid && !frame_err && !key_valid && !ps2_clk_oe, "R11",
              "reset outputs", {byte_valid, frame_err, key_valid, ps2_clk_oe}, 0);
        send(8'h1C, 0);

        cur_req = "R1";
        send(8'h00, 0);
        send(8'hFF, 0);
        send(8'hA5, 0);

        cur_req = "R3";
        send(8'h3A, 0);

        cur_req = "R4";
        send(8'hF0, 0);
        send(8'h1C, 0);

        cur_req = "R5";
        send(8'hE0, 0);
        send(8'h75, 0);
        send(8'hE0, 0);
        send(8'hF0, 0);
        send(8'h75, 0);

        cur_req = "R6";
        send(8'h29, 0);
        send(8'h29, 0);
        send(8'h29, 0);

        cur_req = "R2";
        send(8'h44, 1);
        send(8'h44, 2);
        send(8'h44, 3);
        send(8'h44, 0);

        cur_req = "R7";
        send(8'hE0, 0);
        send(8'hF0, 0);
        send(8'h12, 1);
        send(8'h12, 0);

        cur_req = "R8";
        glitch = 1'b1;
        wait_cyc(FILT - 2);
        glitch = 1'b0;
        wait_cyc(200);
        send(8'h5A, 0);

        cur_req = "R9";
        send_partial(8'h33, 4);
        wait_cyc(IDLE + 300);
        send(8'h33, 0);

        cur_req = "R10";
        for (int k = 0; k < FILT + 6; k++) begin
            send_partial(8'h66, 5);
            dev_dat = 1'b0;
            wait_cyc(HALF);
            dev_clk = 1'b0;
            wait_cyc(k);
            inhibit_i = 1'b1;
            wait_cyc(2);
            check(ps2_clk_oe == 1'b1, "R10", "clock drive while inhibited", ps2_clk_oe, 1);
            wait_cyc(20);
            dev_clk = 1'b1;
            dev_dat = 1'b1;
            wait_cyc(30);
            inhibit_i = 1'b0;
            wait_cyc(2);
            check(ps2_clk_oe == 1'b0, "R10", "clock drive released", ps2_clk_oe, 0);
            wait_cyc(100);
            send(8'h66 + 8'(k), 0);
        end

        wait_cyc(200);
        check(exp_bytes.size() == 0, "R1", "bytes left over", exp_bytes.size(), 0);
        check(exp_evts.size() == 0, "R3", "events left over", exp_evts.size(), 0);
        check(exp_errs == 0, "R2", "errors not seen", exp_errs, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule